// File: doc/BRIEF.md
# Large-Core Bottleneck Request Queue

This block sits beside one large core in an asymmetric multi-core and collects requests from small cores that want a contended code region run on the large core. Each small core owns exactly one slot, so a request from small core k always lands in slot k. A slot keeps the region identifier, the entry address, the stack pointer and a thread-waiting-cycle score. Every hardware context of the large core draws from the same set of slots.

When a large-core context is free, the block hands out the waiting, ready slot with the largest score, and that slot stays occupied until the large core reports that the region has returned. Scores are refreshed while requests wait, by region identifier, so the order adapts as contention shifts. A slot that is ready to run but keeps losing to other work is pulled out after a programmable number of cycles and shipped back to its small core, which then runs the region itself; this prevents an independent request from being serialised behind unrelated, higher-scoring ones.

Top module: `bneck_sched_buf`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `disp_valid`, `back_valid` and `enq_err` are 0 and every slot is empty.
- R2: An accepted request on the `enq_*` inputs fills slot `enq_core` with its identifier, address, stack pointer and score; the same identifier, address and stack pointer later appear unchanged on the `disp_*` or `back_*` outputs for that core.
- R3: Among slots that are waiting and have their `slot_ready` bit at 1, the dispatch choice is the one with the numerically largest score; equal scores resolve to the lowest slot index.
- R4: `disp_valid` is 1 in a cycle exactly when `ctx_free` is 1 and some waiting slot is ready; at most one slot is dispatched per cycle, and a dispatched slot stays occupied, and is not offered again, until its return.
- R5: A pulse on `twc_upd_valid` replaces the score of every occupied slot whose identifier equals `twc_upd_bid` with `twc_upd_val`, effective from the next cycle.
- R6: A waiting slot whose `slot_ready` bit is 0 is never dispatched nor sent back, and its stall count restarts at zero.
- R7: A waiting slot counts consecutive cycles in which it is ready but not dispatched; in the cycle where that count (starting at 0 in the first such cycle) has reached `stall_limit`, it appears on `back_*` and is emptied at the following edge. A slot being dispatched in that cycle is never sent back, and when several are due, the lowest index goes first, one per cycle.
- R8: A pulse on `ret_valid` frees slot `ret_core` only when that slot is currently running on the large core; a return naming a waiting or empty slot has no effect.
- R9: A request into a slot that is already occupied is dropped, leaves the slot's contents unchanged, and drives `enq_err` to 1 for exactly the one cycle after the request.
- R10: Occupancy for an incoming request is judged on the slot's state before that cycle's frees, so a request arriving in the same cycle as the return of that slot is rejected as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Request from a small core is present |
| enq_core | input | IDX_W | Requesting small core, equal to the slot index |
| enq_bid | input | BID_W | Identifier of the contended region |
| enq_pc | input | PC_W | Entry address of the region |
| enq_sp | input | SP_W | Stack pointer of the requesting thread |
| enq_twc | input | TWC_W | Initial waiting-cycle score |
| twc_upd_valid | input | 1 | Score update is present |
| twc_upd_bid | input | BID_W | Region identifier whose score changes |
| twc_upd_val | input | TWC_W | New score |
| slot_ready | input | N | Per-slot ready indication (bit k for slot k) |
| ctx_free | input | 1 | A large-core context can accept work this cycle |
| ret_valid | input | 1 | Large core reports a region return |
| ret_core | input | IDX_W | Slot whose region returned |
| stall_limit | input | CNT_W | Ready-but-waiting cycles tolerated before sending back |
| disp_valid | output | 1 | A slot is dispatched this cycle |
| disp_core | output | IDX_W | Dispatched slot |
| disp_bid | output | BID_W | Dispatched identifier |
| disp_pc | output | PC_W | Dispatched entry address |
| disp_sp | output | SP_W | Dispatched stack pointer |
| back_valid | output | 1 | A slot is sent back this cycle |
| back_core | output | IDX_W | Small core receiving the send-back |
| back_bid | output | BID_W | Identifier sent back |
| back_pc | output | PC_W | Entry address sent back |
| back_sp | output | SP_W | Stack pointer sent back |
| enq_err | output | 1 | Previous cycle's request hit an occupied slot |

## Verification
Dispatch and send-back can both be due in one cycle, either on different slots or on the very same slot. The bench holds two slots not ready, releases them together and keeps the large core busy until both stall counts reach the limit, then frees a context in exactly that cycle: the higher-scoring slot must be dispatched while the other one bounces. A second run lets a lone slot reach its limit in the cycle its context becomes free, and expects a dispatch with no send-back; a request colliding with a return of the same slot is judged the same way against R10.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

  // Life cycle of one slot.
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_RUN   = 2'd2
  } slot_state_e;

endpackage

// File: rtl/bsb_slot.sv
module bsb_slot
  import bsb_pkg::*;
#(
  parameter int BID_W = 8,
  parameter int PC_W  = 16,
  parameter int SP_W  = 16,
  parameter int TWC_W = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BID_W-1:0] ld_bid,
  input  logic [PC_W-1:0]  ld_pc,
  input  logic [SP_W-1:0]  ld_sp,
  input  logic [TWC_W-1:0] ld_twc,
  input  logic             upd_valid,
  input  logic [BID_W-1:0] upd_bid,
  input  logic [TWC_W-1:0] upd_twc,
  input  logic             ready,
  input  logic             grant,
  input  logic             bounce,
  input  logic             retire,
  input  logic [CNT_W-1:0] stall_limit,
  output slot_state_e      state,
  output logic [BID_W-1:0] bid,
  output logic [PC_W-1:0]  pc,
  output logic [SP_W-1:0]  sp,
  output logic [TWC_W-1:0] twc,
  output logic             eligible,
  output logic             stuck
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  slot_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BID_W-1:0] bid_q;
  logic [PC_W-1:0]  pc_q;
  logic [SP_W-1:0]  sp_q;
  logic [TWC_W-1:0] twc_q, twc_d;
  logic             twc_en;

  assign eligible = (state_q == SLOT_WAIT) && ready;
  assign stuck    = eligible && (cnt_q >= stall_limit);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLOT_EMPTY: if (load)   state_d = SLOT_WAIT;
      SLOT_WAIT: begin
        if (grant)            state_d = SLOT_RUN;
        else if (bounce)      state_d = SLOT_EMPTY;
      end
      SLOT_RUN:   if (retire) state_d = SLOT_EMPTY;
      default:                state_d = SLOT_EMPTY;
    endcase
  end

  always_comb begin
    if (eligible && !grant) begin
      cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_comb begin
    twc_en = 1'b0;
    twc_d  = twc_q;
    if (load) begin
      twc_en = 1'b1;
      twc_d  = ld_twc;
    end else if (upd_valid && (state_q != SLOT_EMPTY) && (bid_q == upd_bid)) begin
      twc_en = 1'b1;
      twc_d  = upd_twc;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_EMPTY;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      bid_q <= ld_bid;
      pc_q  <= ld_pc;
      sp_q  <= ld_sp;
    end
  end

  always_ff @(posedge clk) begin
    if (twc_en) begin
      twc_q <= twc_d;
    end
  end

  assign state = state_q;
  assign bid   = bid_q;
  assign pc    = pc_q;
  assign sp    = sp_q;
  assign twc   = twc_q;

endmodule

// File: rtl/bsb_pick.sv
// Largest-score selection; strict compare keeps the lowest index on ties.
module bsb_pick #(
  parameter int N     = 4,
  parameter int TWC_W = 12,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]       elig,
  input  logic [N*TWC_W-1:0] twc_flat,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  logic [TWC_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!any || (twc_flat[i*TWC_W +: TWC_W] > best))) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = twc_flat[i*TWC_W +: TWC_W];
      end
    end
  end

endmodule

// File: rtl/bsb_first.sv
// Lowest set bit finder.
module bsb_first #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/bneck_sched_buf.sv
module bneck_sched_buf
  import bsb_pkg::*;
#(
  parameter int N     = 4,
  parameter int BID_W = 8,
  parameter int PC_W  = 16,
  parameter int SP_W  = 16,
  parameter int TWC_W = 12,
  parameter int CNT_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic [IDX_W-1:0] enq_core,
  input  logic [BID_W-1:0] enq_bid,
  input  logic [PC_W-1:0]  enq_pc,
  input  logic [SP_W-1:0]  enq_sp,
  input  logic [TWC_W-1:0] enq_twc,
  input  logic             twc_upd_valid,
  input  logic [BID_W-1:0] twc_upd_bid,
  input  logic [TWC_W-1:0] twc_upd_val,
  input  logic [N-1:0]     slot_ready,
  input  logic             ctx_free,
  input  logic             ret_valid,
  input  logic [IDX_W-1:0] ret_core,
  input  logic [CNT_W-1:0] stall_limit,
  output logic             disp_valid,
  output logic [IDX_W-1:0] disp_core,
  output logic [BID_W-1:0] disp_bid,
  output logic [PC_W-1:0]  disp_pc,
  output logic [SP_W-1:0]  disp_sp,
  output logic             back_valid,
  output logic [IDX_W-1:0] back_core,
  output logic [BID_W-1:0] back_bid,
  output logic [PC_W-1:0]  back_pc,
  output logic [SP_W-1:0]  back_sp,
  output logic             enq_err
);

  slot_state_e      st    [N];
  logic [BID_W-1:0] bid_a [N];
  logic [PC_W-1:0]  pc_a  [N];
  logic [SP_W-1:0]  sp_a  [N];
  logic [N*TWC_W-1:0] twc_flat;
  logic [N-1:0]     elig, stuck, load, grant, bounce, retire, bounce_req;
  logic             pick_any, back_any;
  logic [IDX_W-1:0] pick_idx, back_idx;
  logic             enq_in_range, enq_busy, enq_bad;
  logic             err_q, err_d;

  // Request admission, judged on the current slot state
  always_comb begin
    enq_in_range = 1'b0;
    enq_busy     = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (enq_core == IDX_W'(i)) begin
        enq_in_range = 1'b1;
        enq_busy     = (st[i] != SLOT_EMPTY);
      end
    end
    enq_bad = enq_valid && (!enq_in_range || enq_busy);
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      assign load[g]   = enq_valid && !enq_bad && (enq_core == IDX_W'(g));
      assign grant[g]  = ctx_free && pick_any && (pick_idx == IDX_W'(g));
      assign bounce[g] = back_any && (back_idx == IDX_W'(g));
      assign retire[g] = ret_valid && (ret_core == IDX_W'(g)) && (st[g] == SLOT_RUN);

      bsb_slot #(
        .BID_W(BID_W), .PC_W(PC_W), .SP_W(SP_W), .TWC_W(TWC_W), .CNT_W(CNT_W)
      ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load[g]),
        .ld_bid     (enq_bid),
        .ld_pc      (enq_pc),
        .ld_sp      (enq_sp),
        .ld_twc     (enq_twc),
        .upd_valid  (twc_upd_valid),
        .upd_bid    (twc_upd_bid),
        .upd_twc    (twc_upd_val),
        .ready      (slot_ready[g]),
        .grant      (grant[g]),
        .bounce     (bounce[g]),
        .retire     (retire[g]),
        .stall_limit(stall_limit),
        .state      (st[g]),
        .bid        (bid_a[g]),
        .pc         (pc_a[g]),
        .sp         (sp_a[g]),
        .twc        (twc_flat[g*TWC_W +: TWC_W]),
        .eligible   (elig[g]),
        .stuck      (stuck[g])
      );
    end
  endgenerate

  bsb_pick #(.N(N), .TWC_W(TWC_W), .IDX_W(IDX_W)) u_pick (
    .elig    (elig),
    .twc_flat(twc_flat),
    .any     (pick_any),
    .idx     (pick_idx)
  );

  // A slot granted this cycle is never a send-back candidate
  assign bounce_req = stuck & ~grant;

  bsb_first #(.N(N), .IDX_W(IDX_W)) u_back (
    .req(bounce_req),
    .any(back_any),
    .idx(back_idx)
  );

  // Output steering
  always_comb begin
    disp_bid = '0;
    disp_pc  = '0;
    disp_sp  = '0;
    back_bid = '0;
    back_pc  = '0;
    back_sp  = '0;
    for (int i = 0; i < N; i++) begin
      if (pick_idx == IDX_W'(i)) begin
        disp_bid = bid_a[i];
        disp_pc  = pc_a[i];
        disp_sp  = sp_a[i];
      end
      if (back_idx == IDX_W'(i)) begin
        back_bid = bid_a[i];
        back_pc  = pc_a[i];
        back_sp  = sp_a[i];
      end
    end
  end

  assign disp_valid = ctx_free && pick_any;
  assign disp_core  = pick_idx;
  assign back_valid = back_any;
  assign back_core  = back_idx;

  // Rejection flag
  assign err_d = enq_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign enq_err = err_q;

endmodule

// File: rtl/bneck_sched_buf_chk.sv
module bneck_sched_buf_chk #(
  parameter int N     = 4,
  parameter int TWC_W = 12,
  parameter int IDX_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctx_free,
  input logic [N-1:0]       slot_ready,
  input logic               enq_valid,
  input logic               enq_err,
  input logic               disp_valid,
  input logic [IDX_W-1:0]   disp_core,
  input logic               back_valid,
  input logic [IDX_W-1:0]   back_core,
  input logic [N-1:0]       elig,
  input logic [N*TWC_W-1:0] twc_flat
);

  // No candidate beats the chosen one, either by score or by index on a tie.
  logic             order_ok;
  logic [TWC_W-1:0] chosen;

  always_comb begin
    chosen   = '0;
    order_ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (disp_core == IDX_W'(i)) chosen = twc_flat[i*TWC_W +: TWC_W];
    end
    for (int i = 0; i < N; i++) begin
      if (elig[i]) begin
        if (twc_flat[i*TWC_W +: TWC_W] > chosen) order_ok = 1'b0;
        if ((twc_flat[i*TWC_W +: TWC_W] == chosen) && (IDX_W'(i) < disp_core)) order_ok = 1'b0;
      end
    end
  end

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> order_ok);

  p_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ctx_free);

  p_no_redispatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !(disp_valid && (disp_core == $past(disp_core))));

  p_ready_for_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    back_valid |-> slot_ready[back_core]);

  p_back_not_disp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && back_valid) |-> (disp_core != back_core));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enq_err |-> $past(enq_valid));

endmodule

bind bneck_sched_buf bneck_sched_buf_chk #(
  .N(N), .TWC_W(TWC_W), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctx_free  (ctx_free),
  .slot_ready(slot_ready),
  .enq_valid (enq_valid),
  .enq_err   (enq_err),
  .disp_valid(disp_valid),
  .disp_core (disp_core),
  .back_valid(back_valid),
  .back_core (back_core),
  .elig      (elig),
  .twc_flat  (twc_flat)
);

// File: tb/bneck_sched_buf_bench.sv
`timescale 1ns/1ps
module bneck_sched_buf_bench;

  localparam int N = 4;
  localparam int IDX_W = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enq_valid;
  logic [1:0]  enq_core;
  logic [7:0]  enq_bid;
  logic [15:0] enq_pc, enq_sp;
  logic [11:0] enq_twc;
  logic        twc_upd_valid;
  logic [7:0]  twc_upd_bid;
  logic [11:0] twc_upd_val;
  logic [3:0]  slot_ready;
  logic        ctx_free;
  logic        ret_valid;
  logic [1:0]  ret_core;
  logic [7:0]  stall_limit;
  logic        disp_valid, back_valid, enq_err;
  logic [1:0]  disp_core, back_core;
  logic [7:0]  disp_bid, back_bid;
  logic [15:0] disp_pc, disp_sp, back_pc, back_sp;

  int n_chk  = 0;
  int n_fail = 0;
  bit timeout = 0;

  always #2 clk = ~clk;

  bneck_sched_buf u_bneck_sched_buf (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_core(enq_core), .enq_bid(enq_bid),
    .enq_pc(enq_pc), .enq_sp(enq_sp), .enq_twc(enq_twc),
    .twc_upd_valid(twc_upd_valid), .twc_upd_bid(twc_upd_bid), .twc_upd_val(twc_upd_val),
    .slot_ready(slot_ready), .ctx_free(ctx_free),
    .ret_valid(ret_valid), .ret_core(ret_core), .stall_limit(stall_limit),
    .disp_valid(disp_valid), .disp_core(disp_core), .disp_bid(disp_bid),
    .disp_pc(disp_pc), .disp_sp(disp_sp),
    .back_valid(back_valid), .back_core(back_core), .back_bid(back_bid),
    .back_pc(back_pc), .back_sp(back_sp),
    .enq_err(enq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance to the next falling edge and drop one-cycle pulses.
  task automatic nxt;
    @(negedge clk);
    enq_valid     = 1'b0;
    twc_upd_valid = 1'b0;
    ret_valid     = 1'b0;
  endtask

  task automatic enq(input logic [1:0] c, input logic [7:0] b, input logic [15:0] p,
                     input logic [15:0] s, input logic [11:0] t);
    nxt;
    enq_valid = 1'b1; enq_core = c; enq_bid = b; enq_pc = p; enq_sp = s; enq_twc = t;
  endtask

  task automatic ret(input logic [1:0] c);
    nxt;
    ret_valid = 1'b1; ret_core = c;
  endtask

  task automatic drain;
    nxt;
    stall_limit = 8'd200; slot_ready = 4'hF; ctx_free = 1'b1;
    repeat (N + 1) nxt;
    ctx_free = 1'b0;
    for (int c = 0; c < N; c++) ret(2'(c));
    nxt;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    enq_valid = 0; enq_core = 0; enq_bid = 0; enq_pc = 0; enq_sp = 0; enq_twc = 0;
    twc_upd_valid = 0; twc_upd_bid = 0; twc_upd_val = 0;
    slot_ready = 4'hF; ctx_free = 1'b1; ret_valid = 0; ret_core = 0; stall_limit = 8'd200;
    repeat (3) @(negedge clk);
    chk("R1 disp in reset", disp_valid, 0);
    chk("R1 back in reset", back_valid, 0);
    chk("R1 err in reset", enq_err, 0);
    rst_n = 1'b1;
    nxt; #1;
    chk("R1 empty after reset", disp_valid, 0);
    ctx_free = 1'b0;
  endtask

  task automatic t_basic;
    enq(2, 8'h11, 16'h1234, 16'h5678, 12'd5);
    nxt; ctx_free = 1'b1; #1;
    chk("R4 dispatch when free", disp_valid, 1);
    chk("R2 disp core", disp_core, 2);
    chk("R2 disp bid", disp_bid, 8'h11);
    chk("R2 disp pc", disp_pc, 16'h1234);
    chk("R2 disp sp", disp_sp, 16'h5678);
    nxt; #1;
    chk("R4 running not offered again", disp_valid, 0);
    ctx_free = 1'b0;
    ret(2);
    enq(2, 8'h12, 16'h1, 16'h2, 12'd1);
    nxt; #1;
    chk("R8 slot freed by return", enq_err, 0);
    drain;
  endtask

  task automatic t_priority;
    enq(0, 8'h01, 16'h10, 16'h0, 12'd7);
    enq(1, 8'h02, 16'h20, 16'h0, 12'd9);
    enq(2, 8'h03, 16'h30, 16'h0, 12'd9);
    enq(3, 8'h04, 16'h40, 16'h0, 12'd3);
    nxt; ctx_free = 1'b1; #1;
    chk("R3 largest score, lowest index on tie", disp_core, 1);
    nxt; #1; chk("R3 tie partner next", disp_core, 2);
    nxt; #1; chk("R3 third", disp_core, 0);
    nxt; #1; chk("R3 lowest score last", disp_core, 3);
    drain;
  endtask

  task automatic t_update;
    enq(0, 8'hA0, 16'h0, 16'h0, 12'd2);
    enq(1, 8'hB0, 16'h0, 16'h0, 12'd6);
    enq(3, 8'hA0, 16'h0, 16'h0, 12'd4);
    nxt; twc_upd_valid = 1'b1; twc_upd_bid = 8'hA0; twc_upd_val = 12'd10;
    nxt; ctx_free = 1'b1; #1;
    chk("R5 updated score wins", disp_core, 0);
    nxt; #1; chk("R5 same id also raised", disp_core, 3);
    nxt; #1; chk("R5 untouched id last", disp_core, 1);
    drain;
  endtask

  task automatic t_not_ready;
    stall_limit = 8'd2; slot_ready = 4'b1110;
    enq(0, 8'h0E, 16'hE0, 16'hE1, 12'd1);
    for (int i = 0; i < 6; i++) begin
      nxt; ctx_free = (i >= 3); #1;
      chk("R6 not ready no dispatch", disp_valid, 0);
      chk("R6 not ready no send-back", back_valid, 0);
    end
    nxt; ctx_free = 1'b0; slot_ready = 4'hF;
    nxt;
    nxt; #1;
    chk("R6 stall count restarts at ready", back_valid, 1);
    chk("R7 send-back core", back_core, 0);
    drain;
  endtask

  task automatic t_bounce;
    stall_limit = 8'd3; slot_ready = 4'b0101; ctx_free = 1'b0;
    enq(2, 8'h22, 16'h2222, 16'h2A2A, 12'd1);
    for (int i = 0; i < 3; i++) begin
      nxt; #1; chk("R7 not yet due", back_valid, 0);
    end
    nxt; #1;
    chk("R7 due at limit", back_valid, 1);
    chk("R7 back core", back_core, 2);
    chk("R2 back bid", back_bid, 8'h22);
    chk("R2 back pc", back_pc, 16'h2222);
    chk("R2 back sp", back_sp, 16'h2A2A);
    nxt; #1; chk("R7 freed after send-back", back_valid, 0);
    enq(3, 8'h33, 16'h3, 16'h3, 12'd1);
    enq(1, 8'h31, 16'h1, 16'h1, 12'd1);
    nxt; slot_ready = 4'hF;
    nxt; nxt;
    nxt; #1; chk("R7 lowest index first", back_core, 1);
    chk("R7 first valid", back_valid, 1);
    nxt; #1; chk("R7 second next cycle", back_core, 3);
    nxt; #1; chk("R7 none left", back_valid, 0);
    enq(1, 8'h41, 16'h1, 16'h1, 12'd1);
    nxt; #1; chk("R7 sent-back slot reusable", enq_err, 0);
    drain;
  endtask

  task automatic t_collide;
    stall_limit = 8'd2; slot_ready = 4'b0000; ctx_free = 1'b0;
    enq(0, 8'h50, 16'h0, 16'h0, 12'd1);
    enq(2, 8'h52, 16'h0, 16'h0, 12'd8);
    nxt; slot_ready = 4'b0101; #1; chk("R7 c0 quiet", back_valid, 0);
    nxt; #1; chk("R7 c1 quiet", back_valid, 0);
    nxt; ctx_free = 1'b1; #1;
    chk("R3 dispatch higher score", disp_core, 2);
    chk("R7 other slot bounces same cycle", back_valid, 1);
    chk("R7 bounced core", back_core, 0);
    nxt; #1;
    chk("R7 both gone next cycle", {disp_valid, back_valid}, 0);
    ctx_free = 1'b0;
    ret(2);
    slot_ready = 4'hF;
    enq(1, 8'h61, 16'h0, 16'h0, 12'd3);
    nxt; nxt;
    nxt; ctx_free = 1'b1; #1;
    chk("R7 due slot dispatched", disp_core, 1);
    chk("R7 dispatch beats send-back", back_valid, 0);
    drain;
  endtask

  task automatic t_return;
    ctx_free = 1'b0;
    enq(3, 8'h33, 16'h3300, 16'h3301, 12'd2);
    ret(3);
    nxt; ctx_free = 1'b1; #1;
    chk("R8 return on waiting slot ignored", disp_valid, 1);
    chk("R8 waiting slot kept", disp_bid, 8'h33);
    nxt; ctx_free = 1'b0;
    ret(3);
    enq(3, 8'h34, 16'h0, 16'h0, 12'd1);
    nxt; #1; chk("R8 return frees running slot", enq_err, 0);
    drain;
  endtask

  task automatic t_enq_err;
    ctx_free = 1'b0;
    enq(2, 8'h44, 16'h4400, 16'h4401, 12'd4);
    enq(2, 8'h55, 16'h5500, 16'h5501, 12'd9);
    nxt; #1; chk("R9 error after occupied request", enq_err, 1);
    nxt; #1; chk("R9 error lasts one cycle", enq_err, 0);
    ctx_free = 1'b1; #1;
    chk("R9 contents unchanged", disp_bid, 8'h44);
    nxt; ctx_free = 1'b0;
    nxt; ret_valid = 1'b1; ret_core = 2;
    enq_valid = 1'b1; enq_core = 2; enq_bid = 8'h66; enq_pc = 0; enq_sp = 0; enq_twc = 1;
    nxt; #1; chk("R10 request with same-cycle return rejected", enq_err, 1);
    enq(2, 8'h77, 16'h0, 16'h0, 12'd1);
    nxt; #1; chk("R10 accepted after return", enq_err, 0);
    ctx_free = 1'b1; #1;
    chk("R10 new contents", disp_bid, 8'h77);
    drain;
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_basic;
        t_priority;
        t_update;
        t_not_ready;
        t_bounce;
        t_collide;
        t_return;
        t_enq_err;
      end
      begin
        repeat (20000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule